// File: doc/BRIEF.md
# Indirect Tuning Parameter Mailbox

This block lets software reach a small set of 16-bit tuning parameters of a PCIe core through three registers. Software names the parameter with a selector in the control register: a main code and a subcode. It then writes the data register. That single write starts one transaction on an internal parameter bus. The value written decides whether the transaction reads the parameter or writes it.

While the transaction runs, a busy bit in the status register stays set. When a read finishes, the parameter value is placed in the data register. The parameter bank sits behind the bus and is modelled here as a small register file. The bank holds the transmit completion, non-posted and posted weights and the receive and transmit buffer levels. A selector that names no parameter still completes normally, and it has no effect.

Top module: `tune_mailbox`

## Requirements
- R1: After reset the control, data and status registers all read 0.
- R2: The control register is at address 0. It holds the main code in bits [15:0] and the subcode in bits [23:16]. Bits [31:24] read as 0.
- R3: The data register is at address 1. Writing any value other than 32'hFFFFFFFF to it while idle starts a parameter write. That write stores bits [15:0] of the value into the selected parameter, and the data register keeps the value that was written.
- R4: Writing 32'hFFFFFFFF to the data register while idle starts a parameter read. When the read completes, the data register holds the parameter value zero-extended from bits [15:0].
- R5: The status register is at address 2, with a busy flag in bit 0. Busy is set by the edge that accepts a data write and stays set for exactly 4 clock cycles, then clears. The internal bus signals completion with a one-cycle done pulse.
- R6: The implemented selectors (main code, subcode) are (4,3), (4,4), (4,5), (5,6) and (5,7). Each selector keeps its own parameter storage, and every parameter resets to 0.
- R7: A selector outside that set completes with the normal timing. A read of it returns 0, and a write to it changes no parameter.
- R8: A data-register write while busy is set is ignored. The data register is unchanged, and neither the ongoing transaction nor its end time is affected.
- R9: A parameter read leaves the parameter unchanged, so repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; reg_rdata updates on the same edge |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The main function is driven with a write-then-read pass over all five selectors, using distinct values. If two selectors aliased onto the same storage, one of them would read back the wrong value. Two unimplemented selectors are also used, one with a valid main code and one with a valid subcode, so that a partial decode shows up. Further cases cover:
- write data whose upper half is nonzero, to check that only the low bits are stored;
- a value whose low half is all ones but which is not the read pattern, to check that only the full all-ones word starts a read;
- a cycle-by-cycle busy trace, with and without a second data write during busy, to check both the exact latency and that a write during busy neither restarts nor extends the transaction.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int VAL_W  = 16;
  localparam int CODE_W = 16;
  localparam int SUB_W  = 8;
  localparam int NPAR   = 5;
  localparam int IDX_W  = $clog2(NPAR);

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } slot_t;

  // Map a (main code, subcode) selector onto a parameter slot.
  function automatic slot_t lookup(input logic [CODE_W-1:0] code,
                                   input logic [SUB_W-1:0]  sub);
    slot_t s;
    s.hit = 1'b1;
    s.idx = '0;
    case ({code, sub})
      {CODE_W'(4), SUB_W'(3)}: s.idx = IDX_W'(0);
      {CODE_W'(4), SUB_W'(4)}: s.idx = IDX_W'(1);
      {CODE_W'(4), SUB_W'(5)}: s.idx = IDX_W'(2);
      {CODE_W'(5), SUB_W'(6)}: s.idx = IDX_W'(3);
      {CODE_W'(5), SUB_W'(7)}: s.idx = IDX_W'(4);
      default:                 s.hit = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/tune_seq.sv
module tune_seq #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic req,
  output logic done
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == CNT_W'(LAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      req  <= 1'b0;
    end else begin
      req <= start;
      if (start) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(1);
      end else if (done) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> busy);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);
  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/tune_bank.sv
module tune_bank
  import tune_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [CODE_W-1:0] code,
  input  logic [SUB_W-1:0]  sub,
  input  logic [VAL_W-1:0]  wval,
  output logic [VAL_W-1:0]  rval
);
  logic [VAL_W-1:0] mem [NPAR];
  slot_t            slot;

  assign slot = lookup(code, sub);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPAR; i++) mem[i] <= '0;
      rval <= '0;
    end else if (req) begin
      if (we && slot.hit) mem[slot.idx] <= wval;
      rval <= slot.hit ? mem[slot.idx] : '0;
    end
  end

  // R7
  miss_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    req && !slot.hit |=> rval == '0);
endmodule

// File: rtl/tune_front.sv
module tune_front
  import tune_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [VAL_W-1:0]  bank_rval,
  output logic              start,
  output logic              op_wr,
  output logic [CODE_W-1:0] sel_code,
  output logic [SUB_W-1:0]  sel_sub,
  output logic [VAL_W-1:0]  wval
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  logic [CODE_W-1:0] code_q;
  logic [SUB_W-1:0]  sub_q;
  logic [DATA_W-1:0] data_q;
  logic              data_wr;

  assign data_wr = reg_wr && (reg_addr == A_DATA);
  assign start   = data_wr && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q    <= '0;
      sub_q     <= '0;
      data_q    <= '0;
      op_wr     <= 1'b0;
      sel_code  <= '0;
      sel_sub   <= '0;
      wval      <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) begin
        code_q <= reg_wdata[CODE_W-1:0];
        sub_q  <= reg_wdata[CODE_W+SUB_W-1:CODE_W];
      end
      if (start) begin
        data_q   <= reg_wdata;
        op_wr    <= (reg_wdata != '1);
        sel_code <= code_q;
        sel_sub  <= sub_q;
        wval     <= reg_wdata[VAL_W-1:0];
      end else if (done && !op_wr) begin
        data_q <= DATA_W'(bank_rval);
      end
      if (reg_rd) begin
        case (reg_addr)
          A_CTRL:  reg_rdata <= DATA_W'({sub_q, code_q});
          A_DATA:  reg_rdata <= data_q;
          A_STAT:  reg_rdata <= DATA_W'(busy);
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    data_wr && busy && !done |=> $stable(data_q));
endmodule

// File: rtl/tune_mailbox.sv
module tune_mailbox
  import tune_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic              start, busy, req, done, op_wr;
  logic [CODE_W-1:0] sel_code;
  logic [SUB_W-1:0]  sel_sub;
  logic [VAL_W-1:0]  wval, rval;

  tune_front #(.DATA_W(DATA_W)) u_front (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .bank_rval(rval), .start(start),
    .op_wr(op_wr), .sel_code(sel_code), .sel_sub(sel_sub), .wval(wval)
  );

  tune_seq #(.LAT(LAT)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .req(req), .done(done)
  );

  tune_bank u_bank (
    .clk(clk), .rst(rst), .req(req), .we(op_wr), .code(sel_code),
    .sub(sel_sub), .wval(wval), .rval(rval)
  );

  // R5
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> busy && !done);
endmodule

// File: tb/tb_tune_mailbox.sv
module tb_tune_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RD_PAT = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tune_mailbox dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {is_read, main code, subcode, value (write) or expected (read)}
  localparam logic [40:0] VEC [16] = '{
    {1'b0, 16'h0004, 8'h03, 16'h1111},
    {1'b0, 16'h0004, 8'h04, 16'h2222},
    {1'b0, 16'h0004, 8'h05, 16'h3333},
    {1'b0, 16'h0005, 8'h06, 16'h4444},
    {1'b0, 16'h0005, 8'h07, 16'h5555},
    {1'b0, 16'h0004, 8'h06, 16'h7777},
    {1'b1, 16'h0004, 8'h03, 16'h1111},
    {1'b1, 16'h0004, 8'h04, 16'h2222},
    {1'b1, 16'h0004, 8'h05, 16'h3333},
    {1'b1, 16'h0005, 8'h06, 16'h4444},
    {1'b1, 16'h0005, 8'h07, 16'h5555},
    {1'b1, 16'h0004, 8'h06, 16'h0000},
    {1'b1, 16'h0005, 8'h03, 16'h0000},
    {1'b0, 16'h0004, 8'h03, 16'hFFFE},
    {1'b1, 16'h0004, 8'h03, 16'hFFFE},
    {1'b1, 16'h0004, 8'h03, 16'hFFFE}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 50; n++) begin
      rd_reg(2'd2, s);
      if (s[0] == 1'b0) return;
    end
    check("R5 idle", s, 32'h0);
  endtask

  task automatic param_read(input logic [15:0] c, input logic [7:0] s, output logic [31:0] d);
    wr_reg(2'd0, {8'h00, s, c});
    wr_reg(2'd1, RD_PAT);
    wait_idle();
    rd_reg(2'd1, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_reg(2'd0, v); check("R1 ctrl", v, 32'h0);
    rd_reg(2'd1, v); check("R1 data", v, 32'h0);
    rd_reg(2'd2, v); check("R1 status", v, 32'h0);
    // R6 parameters reset to 0
    param_read(16'h0005, 8'h07, v); check("R6 reset value", v, 32'h0);

    // R2 control field layout, top byte dropped
    wr_reg(2'd0, 32'hDE12_ABCD);
    rd_reg(2'd0, v); check("R2 ctrl fields", v, 32'h0012_ABCD);

    // Vector table: R3 R4 R6 R7 R9
    for (int i = 0; i < 16; i++) begin
      logic [40:0] e;
      e = VEC[i];
      if (!e[40]) begin
        wr_reg(2'd0, {8'h00, e[23:16], e[39:24]});
        wr_reg(2'd1, {16'hA5A5, e[15:0]});
        wait_idle();
        rd_reg(2'd1, v);
        check("R3 data holds written value", v, {16'hA5A5, e[15:0]});
      end else begin
        param_read(e[39:24], e[23:16], v);
        check("R4 R6 R7 R9 table read", v, {16'h0, e[15:0]});
      end
    end

    // R3: low half all ones, upper zero, is a write
    wr_reg(2'd0, {8'h00, 8'h07, 16'h0005});
    wr_reg(2'd1, 32'h0000_FFFF);
    wait_idle();
    param_read(16'h0005, 8'h07, v); check("R3 0000FFFF writes", v, 32'h0000_FFFF);

    // R5 exact busy window
    wr_reg(2'd0, {8'h00, 8'h05, 16'h0004});
    wr_reg(2'd1, 32'h0000_0ABC);
    for (int k = 0; k < 4; k++) begin
      rd_reg(2'd2, v); check("R5 busy during latency", v, 32'h1);
    end
    rd_reg(2'd2, v); check("R5 busy cleared", v, 32'h0);

    // R8 write while busy ignored
    wr_reg(2'd0, {8'h00, 8'h04, 16'h0004});
    wr_reg(2'd1, 32'h0000_0BBB);
    wr_reg(2'd1, 32'h0000_0CCC);
    for (int k = 0; k < 3; k++) begin
      rd_reg(2'd2, v); check("R8 busy unchanged", v, 32'h1);
    end
    rd_reg(2'd2, v); check("R8 ends on original time", v, 32'h0);
    rd_reg(2'd1, v); check("R8 data kept", v, 32'h0000_0BBB);
    param_read(16'h0004, 8'h04, v); check("R8 param kept", v, 32'h0000_0BBB);
    param_read(16'h0004, 8'h05, v); check("R5 param written", v, 32'h0000_0ABC);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule